// File: doc/BRIEF.md
# Power-Pulse Cycle Controller with Wake-Up Trigger Veto

This block sits on a front-end acquisition board and paces the power of the front-end chips. It runs a free-running cycle of `PERIOD_CYC` clocks. Only the last `ON_CYC` clocks of each cycle are a power-on window. Three supply lines (analog, DAC, digital) can each be switched with that window or held on all the time, chosen by one configuration bit per line.

When power comes up, the chips need time to wake before they hold valid data. For `WAKE_CYC` clocks after each power-on edge the block therefore refuses every external trigger. After that wake-up time it raises an enable-acquisition output and lets triggers through, unless the readout reports busy. Outside the window every trigger is refused, so nothing is recorded while the chips sleep.

Accepted triggers come out as a one-clock pulse. Two counters track each cycle: one for accepted triggers and one for refused triggers. Both counters restart at every power-on edge and both saturate.

Top module: `pwr_cycle_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `pwr_on`, `acq_en` and `trig_acc` are 0, and `acc_cnt` and `rej_cnt` are 0.
- R2: The cycle phase is 0 in the first cycle after reset and advances by one per clock, wrapping after `PERIOD_CYC - 1`. `pwr_on` is 1 exactly at phases `PERIOD_CYC - ON_CYC` through `PERIOD_CYC - 1`. The first power-on edge therefore comes `PERIOD_CYC - ON_CYC` clocks after reset release.
- R3: `acq_en` is 0 during the first `WAKE_CYC` clocks of each power-on window. It is 1 for the rest of the window and 0 whenever `pwr_on` is 0.
- R4: A trigger is accepted when `trig_in` is 1 in a clock where `acq_en` is 1 and `busy_in` is 0. `trig_acc` is 1 in the following clock, and `acc_cnt` is one higher in the following clock.
- R5: A trigger sampled while `busy_in` is 1 is refused: `trig_acc` stays 0, `acc_cnt` is unchanged and `rej_cnt` rises by one.
- R6: A trigger sampled while `pwr_on` is 0, or inside the wake-up time, is refused and counted in `rej_cnt`.
- R7: In the first clock of each power-on window both counters restart. The next clock shows `acc_cnt` = 0, and shows `rej_cnt` = 1 if a trigger arrived in that first clock, otherwise 0.
- R8: Both counters saturate at 2^`CNT_W` - 1 and do not wrap.
- R9: `line_en` bit 0 is the analog line, bit 1 the DAC line and bit 2 the digital line. When `cfg_pulse[i]` is 1, line i follows `pwr_on`. When it is 0, line i is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pulse | input | 3 | Per-line select: 1 = pulsed, 0 = always on |
| trig_in | input | 1 | External trigger, sampled every clock |
| busy_in | input | 1 | Readout busy; blocks acceptance |
| pwr_on | output | 1 | Power-on window |
| acq_en | output | 1 | Enable-acquisition, after wake-up time |
| line_en | output | 3 | Supply line enables (analog, DAC, digital) |
| trig_acc | output | 1 | One-clock pulse per accepted trigger |
| acc_cnt | output | CNT_W | Accepted triggers in this window |
| rej_cnt | output | CNT_W | Refused triggers since last power-on edge |

## Verification
The assertions take the parameters to satisfy 1 <= `WAKE_CYC` < `ON_CYC` < `PERIOD_CYC`. They also take `trig_in` and `busy_in` to be synchronous levels that are only meaningful when sampled at a clock edge. The bench changes every input on the falling edge, so each value is stable across the rising edge that samples it. It places triggers at phases derived from its own count of clocks since reset: the window boundaries, the wake-up boundary, busy periods and a saturating burst.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int N_LINES = 3;

    typedef enum logic [1:0] {
        LINE_ANALOG = 2'd0,
        LINE_DAC    = 2'd1,
        LINE_DIGIT  = 2'd2
    } line_id_e;

    typedef enum logic [2:0] {
        TV_NONE     = 3'd0,
        TV_ACCEPT   = 3'd1,
        TV_REJ_OFF  = 3'd2,
        TV_REJ_WAKE = 3'd3,
        TV_REJ_BUSY = 3'd4
    } trig_verdict_e;
endpackage

// File: rtl/pp_phase_timer.sv
module pp_phase_timer #(
    parameter int PERIOD_CYC = 100,
    parameter int ON_CYC     = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwr_on,
    output logic on_start
);
    localparam int PH_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [PH_W-1:0] OFF_START = PH_W'(PERIOD_CYC - ON_CYC);
    localparam logic [PH_W-1:0] LAST_PH   = PH_W'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.phase == LAST_PH) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        pwr_on   = (st_q.phase >= OFF_START);
        on_start = (st_q.phase == OFF_START);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pp_wake_veto.sv
module pp_wake_veto #(
    parameter int WAKE_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_on,
    input  logic on_start,
    output logic acq_en,
    output logic in_wake
);
    localparam int WK_W = $clog2(WAKE_CYC + 1);
    localparam logic [WK_W-1:0] WAKE_RELOAD = WK_W'(WAKE_CYC - 1);

    typedef struct packed {
        logic [WK_W-1:0] left;
    } wake_st_t;

    wake_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (on_start) begin
            st_d.left = WAKE_RELOAD;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
        if (!pwr_on) begin
            st_d.left = on_start ? WAKE_RELOAD : '0;
        end
        in_wake = pwr_on && (on_start || (st_q.left != '0));
        acq_en  = pwr_on && !in_wake;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pp_trig_gate.sv
module pp_trig_gate
    import pp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             busy_in,
    input  logic             pwr_on,
    input  logic             in_wake,
    input  logic             on_start,
    output logic             trig_acc,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] rej_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             acc_pulse;
        logic [CNT_W-1:0] acc;
        logic [CNT_W-1:0] rej;
    } gate_st_t;

    gate_st_t      st_d, st_q;
    trig_verdict_e verdict;
    logic          is_rej;

    always_comb begin
        if (!trig_in) begin
            verdict = TV_NONE;
        end else if (!pwr_on) begin
            verdict = TV_REJ_OFF;
        end else if (in_wake) begin
            verdict = TV_REJ_WAKE;
        end else if (busy_in) begin
            verdict = TV_REJ_BUSY;
        end else begin
            verdict = TV_ACCEPT;
        end
        is_rej = (verdict == TV_REJ_OFF) || (verdict == TV_REJ_WAKE) ||
                 (verdict == TV_REJ_BUSY);
    end

    always_comb begin
        st_d           = st_q;
        st_d.acc_pulse = (verdict == TV_ACCEPT);
        if (on_start) begin
            st_d.acc = '0;
            st_d.rej = is_rej ? CNT_W'(1) : '0;
        end else begin
            if ((verdict == TV_ACCEPT) && (st_q.acc != CNT_MAX)) begin
                st_d.acc = st_q.acc + 1'b1;
            end
            if (is_rej && (st_q.rej != CNT_MAX)) begin
                st_d.rej = st_q.rej + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_acc = st_q.acc_pulse;
    assign acc_cnt  = st_q.acc;
    assign rej_cnt  = st_q.rej;
endmodule

// File: rtl/pp_line_sel.sv
module pp_line_sel
    import pp_pkg::*;
(
    input  logic               pwr_on,
    input  logic [N_LINES-1:0] cfg_pulse,
    output logic [N_LINES-1:0] line_en
);
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        always_comb begin
            line_en[g] = cfg_pulse[g] ? pwr_on : 1'b1;
        end
    end
endmodule

// File: rtl/pwr_cycle_ctrl.sv
module pwr_cycle_ctrl
    import pp_pkg::*;
#(
    parameter int PERIOD_CYC = 100,
    parameter int ON_CYC     = 20,
    parameter int WAKE_CYC   = 5,
    parameter int CNT_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] cfg_pulse,
    input  logic               trig_in,
    input  logic               busy_in,
    output logic               pwr_on,
    output logic               acq_en,
    output logic [N_LINES-1:0] line_en,
    output logic               trig_acc,
    output logic [CNT_W-1:0]   acc_cnt,
    output logic [CNT_W-1:0]   rej_cnt
);
    logic on_start;
    logic in_wake;

    pp_phase_timer #(.PERIOD_CYC(PERIOD_CYC), .ON_CYC(ON_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .on_start (on_start)
    );

    pp_wake_veto #(.WAKE_CYC(WAKE_CYC)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_on   (pwr_on),
        .on_start (on_start),
        .acq_en   (acq_en),
        .in_wake  (in_wake)
    );

    pp_trig_gate #(.CNT_W(CNT_W)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_in  (trig_in),
        .busy_in  (busy_in),
        .pwr_on   (pwr_on),
        .in_wake  (in_wake),
        .on_start (on_start),
        .trig_acc (trig_acc),
        .acc_cnt  (acc_cnt),
        .rej_cnt  (rej_cnt)
    );

    pp_line_sel u_lines (
        .pwr_on    (pwr_on),
        .cfg_pulse (cfg_pulse),
        .line_en   (line_en)
    );
endmodule

// File: rtl/pp_ctrl_chk.sv
module pp_ctrl_chk #(
    parameter int ON_CYC   = 20,
    parameter int WAKE_CYC = 5,
    parameter int CNT_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       cfg_pulse,
    input logic             trig_in,
    input logic             busy_in,
    input logic             pwr_on,
    input logic             acq_en,
    input logic [2:0]       line_en,
    input logic             trig_acc,
    input logic [CNT_W-1:0] acc_cnt,
    input logic [CNT_W-1:0] rej_cnt
);
    int unsigned on_age_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_age_q <= 0;
        end else begin
            on_age_q <= pwr_on ? on_age_q + 1 : 0;
        end
    end

    a_r2_window_len: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on |-> (on_age_q < ON_CYC));
    a_r3_acq_needs_pwr: assert property (@(posedge clk) disable iff (!rst_n)
        acq_en |-> pwr_on);
    a_r3_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        acq_en |-> (on_age_q >= WAKE_CYC));
    a_r4_acc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        trig_acc |-> $past(trig_in && acq_en && !busy_in));
    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy_in |=> !trig_acc);
    a_r7_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |=> (acc_cnt == '0));
    a_r7_rej_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_on) |=> (rej_cnt <= CNT_W'(1)));
    a_r8_acc_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_cnt == {CNT_W{1'b1}} && !$rose(pwr_on)) |=> (acc_cnt == {CNT_W{1'b1}}));
    a_r9_analog_on: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pulse[0] |-> line_en[0]);
    a_r9_dac_on: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pulse[1] |-> line_en[1]);
    a_r9_digit_on: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_pulse[2] |-> line_en[2]);
    a_r9_pulsed_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> ((line_en & cfg_pulse) == 3'b000));
endmodule

bind pwr_cycle_ctrl pp_ctrl_chk #(
    .ON_CYC   (ON_CYC),
    .WAKE_CYC (WAKE_CYC),
    .CNT_W    (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pulse (cfg_pulse),
    .trig_in   (trig_in),
    .busy_in   (busy_in),
    .pwr_on    (pwr_on),
    .acq_en    (acq_en),
    .line_en   (line_en),
    .trig_acc  (trig_acc),
    .acc_cnt   (acc_cnt),
    .rej_cnt   (rej_cnt)
);

// File: tb/sim_pwr_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_cycle_ctrl;
    localparam int PER = 100;
    localparam int ON  = 20;
    localparam int WK  = 5;
    localparam int CW  = 3;
    localparam int OFF = PER - ON;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_pulse = 3'b111;
    logic          trig_in = 1'b0;
    logic          busy_in = 1'b0;
    logic          pwr_on, acq_en, trig_acc;
    logic [2:0]    line_en;
    logic [CW-1:0] acc_cnt, rej_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int edges   = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (rst_n) edges <= edges + 1;

    pwr_cycle_ctrl #(.PERIOD_CYC(PER), .ON_CYC(ON), .WAKE_CYC(WK), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_pulse(cfg_pulse), .trig_in(trig_in),
        .busy_in(busy_in), .pwr_on(pwr_on), .acq_en(acq_en), .line_en(line_en),
        .trig_acc(trig_acc), .acc_cnt(acc_cnt), .rej_cnt(rej_cnt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (phase %0d)", tag, act, exp, edges % PER);
        end
    endtask

    task automatic wait_phase(input int p);
        @(negedge clk);
        while ((edges % PER) != p) @(negedge clk);
    endtask

    task automatic pulse_trig(input int p);
        wait_phase(p);
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 pwr_on in reset", pwr_on, 0);
        chk("R1 acq_en in reset", acq_en, 0);
        chk("R1 trig_acc in reset", trig_acc, 0);
        chk("R1 acc_cnt in reset", acc_cnt, 0);
        chk("R1 rej_cnt in reset", rej_cnt, 0);
        chk("R9 pulsed lines off in reset", line_en, 0);
        rst_n = 1'b1;
        chk("R1 pwr_on after release", pwr_on, 0);
    endtask

    task automatic t_window;
        wait_phase(OFF - 1);
        chk("R2 off before window", pwr_on, 0);
        wait_phase(OFF);
        chk("R2 on at window start", pwr_on, 1);
        chk("R2 first rise delay", edges, OFF);
        chk("R9 pulsed lines follow", line_en, 7);
    endtask

    task automatic t_wake;
        pulse_trig(OFF + 2);
        chk("R6 wake trigger not accepted", trig_acc, 0);
        chk("R6 wake trigger counted", rej_cnt, 1);
        wait_phase(OFF + WK - 1);
        chk("R3 veto at last wake cycle", acq_en, 0);
        wait_phase(OFF + WK);
        chk("R3 acq open after wake", acq_en, 1);
    endtask

    task automatic t_accept;
        pulse_trig(OFF + 10);
        chk("R4 trig_acc pulse", trig_acc, 1);
        chk("R4 acc_cnt incremented", acc_cnt, 1);
        @(negedge clk);
        chk("R4 trig_acc one clock", trig_acc, 0);
    endtask

    task automatic t_busy;
        wait_phase(OFF + 13);
        busy_in = 1'b1;
        trig_in = 1'b1;
        @(negedge clk);
        trig_in = 1'b0;
        busy_in = 1'b0;
        chk("R5 busy refuses", trig_acc, 0);
        chk("R5 acc_cnt unchanged", acc_cnt, 1);
        chk("R5 rej_cnt up", rej_cnt, 2);
    endtask

    task automatic t_wrap_off;
        wait_phase(0);
        chk("R2 off after wrap", pwr_on, 0);
        chk("R3 acq off after wrap", acq_en, 0);
        pulse_trig(30);
        chk("R6 off trigger refused", trig_acc, 0);
        chk("R6 off trigger counted", rej_cnt, 3);
        chk("R6 acc held while off", acc_cnt, 1);
    endtask

    task automatic t_clear;
        pulse_trig(OFF);
        chk("R7 acc cleared", acc_cnt, 0);
        chk("R7 rej restarts at one", rej_cnt, 1);
    endtask

    task automatic t_saturate;
        wait_phase(OFF + WK);
        trig_in = 1'b1;
        wait_phase(0);
        trig_in = 1'b0;
        chk("R8 acc saturated", acc_cnt, 7);
        @(negedge clk);
        chk("R8 acc held", acc_cnt, 7);
    endtask

    task automatic t_config;
        wait_phase(10);
        cfg_pulse = 3'b010;
        #1;
        chk("R9 always-on analog and digital while off", line_en, 5);
        wait_phase(OFF + 1);
        chk("R9 all on in window", line_en, 7);
        wait_phase(5);
        cfg_pulse = 3'b101;
        #1;
        chk("R9 only DAC always-on", line_en, 2);
        cfg_pulse = 3'b111;
        #1;
        chk("R9 all pulsed while off", line_en, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset;
        t_window;
        t_wake;
        t_accept;
        t_busy;
        t_wrap_off;
        t_clear;
        t_saturate;
        t_config;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule